// File: doc/BRIEF.md
# Predicated Saturating Multiply-High Lane Unit

This block performs a lane-wise multiply-high on a 128-bit vector. The second operand is either another 128-bit vector or a 32-bit scalar that is replicated into every lane. Lanes are 8, 16 or 32 bits wide. Four operations are available. Two of them are a plain multiply-high and a rounding multiply-high, and each can take signed or unsigned lanes. The other two are a saturating doubling multiply-high and its rounding form, and both always treat lanes as signed. The doubling is folded into a right shift by one less than the lane width. The rounding constant is adjusted to match that shift.

A byte-enable vector merges the results into the previous destination value. Disabled bytes keep their old contents. A sticky flag records any saturation in a lane whose lowest byte is enabled. The flag stays set until a dedicated clear input is asserted. The block does not generate the byte-enable vector; a predication unit elsewhere supplies it.

A valid strobe launches one operation. The merged destination and the updated flag appear at the registered outputs one clock later.

Top module: `mulh_lane_unit`

## Requirements
- R1: Plain multiply-high (op_sel 0): each result lane is the full product of the two lanes shifted right by the lane width W, keeping the low W bits. Lanes are sign-extended when op_unsigned is 0 and zero-extended when it is 1.
- R2: Rounding multiply-high (op_sel 1): the same as R1, except that 2^(W-1) is added to the product before the shift.
- R3: Saturating doubling multiply-high (op_sel 2): the signed product is arithmetically shifted right by W-1 and clamped to [-2^(W-1), 2^(W-1)-1]. op_unsigned has no effect on this operation.
- R4: Rounding saturating doubling multiply-high (op_sel 3): 2^(W-2) is added to the signed product before the shift by W-1. The result is then clamped as in R3, and op_unsigned again has no effect.
- R5: elem_size 0 selects 8-bit lanes (16 lanes), 1 selects 16-bit lanes (8 lanes), and 2 or 3 selects 32-bit lanes (4 lanes). Lane e occupies bits [e*W +: W].
- R6: When scalar_sel is 1, the low W bits of scalar_b are the second operand of every lane and vec_b is ignored.
- R7: Byte j of dest_new takes the result byte when byte_en[j] is 1 and takes dest_old byte j when byte_en[j] is 0.
- R8: A lane's saturation counts toward the flag only when byte_en holds a 1 at that lane's lowest byte, bit e*W/8.
- R9: sat_flag is sticky. It is cleared only by sat_clr. If a clear and a counted saturation arrive in the same cycle, the flag ends up set.
- R10: The outputs are registered. out_valid is 1 exactly one cycle after in_valid. dest_new holds its value in cycles that follow no strobe. Reset (active-low rst_n) gives dest_new = 0, out_valid = 0 and sat_flag = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Launches one operation |
| op_sel | input | 2 | 0 plain, 1 rounding, 2 saturating doubling, 3 rounding saturating doubling |
| op_unsigned | input | 1 | Unsigned lanes for op_sel 0 and 1 |
| elem_size | input | 2 | Lane width code (R5) |
| scalar_sel | input | 1 | Use the replicated scalar as the second operand |
| vec_a | input | 128 | First operand vector |
| vec_b | input | 128 | Second operand vector |
| scalar_b | input | 32 | Scalar second operand |
| dest_old | input | 128 | Previous destination value |
| byte_en | input | 16 | Per-byte write enable |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| dest_new | output | 128 | Merged destination |
| out_valid | output | 1 | Result strobe |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A wrong lane selection or a wrong shift inside a bank shows up as a wrong byte of dest_new in the cycle right after the strobe. The wrong byte lies only in the enabled positions, so the tests pair full masks with sparse masks. A flag-gating error appears as sat_flag rising or failing to rise one cycle after a saturating operation whose lowest lane byte is disabled or enabled. Once the flag is wrong, its sticky nature keeps it wrong until the next clear, so the bench checks the flag after every operation.

// File: rtl/mulh_pkg.sv
package mulh_pkg;

   typedef enum logic [1:0] {
      MH_PLAIN      = 2'd0,
      MH_ROUND      = 2'd1,
      MH_SATDBL     = 2'd2,
      MH_SATDBL_RND = 2'd3
   } mh_op_e;

   localparam int N_SIZES  = 3;
   localparam int MIN_LANE = 8;

   function automatic int lane_width(input int idx);
      return MIN_LANE << idx;
   endfunction

   function automatic logic is_sat_op(input mh_op_e op);
      return (op == MH_SATDBL) || (op == MH_SATDBL_RND);
   endfunction

endpackage

// File: rtl/mulh_core.sv
module mulh_core
   import mulh_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  mh_op_e       op_i,
   input  logic         uns_i,
   output logic [W-1:0] res_o,
   output logic         sat_o
);
   localparam int PW = 2 * W + 2;
   localparam logic signed [PW-1:0] SMAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [PW-1:0] SMIN = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

   generate
      if (W < 4) begin : g_bad_width
         $error("mulh_core: lane width must be at least 4");
      end
   endgenerate

   logic                 sat_mode;
   logic                 zero_ext;
   logic signed [PW-1:0] a_x, b_x, prod, rnd, biased, shifted;

   assign sat_mode = is_sat_op(op_i);
   assign zero_ext = uns_i & ~sat_mode;

   assign a_x = zero_ext ? {{(PW-W){1'b0}}, a_i} : {{(PW-W){a_i[W-1]}}, a_i};
   assign b_x = zero_ext ? {{(PW-W){1'b0}}, b_i} : {{(PW-W){b_i[W-1]}}, b_i};
   assign prod = a_x * b_x;

   always_comb begin
      rnd = '0;
      case (op_i)
         MH_ROUND:      rnd[W-1] = 1'b1;
         MH_SATDBL_RND: rnd[W-2] = 1'b1;
         default:       rnd = '0;
      endcase
   end

   assign biased  = prod + rnd;
   assign shifted = sat_mode ? (biased >>> (W - 1)) : (biased >>> W);

   always_comb begin
      res_o = shifted[W-1:0];
      sat_o = 1'b0;
      if (sat_mode) begin
         if (shifted > SMAX) begin
            res_o = SMAX[W-1:0];
            sat_o = 1'b1;
         end else if (shifted < SMIN) begin
            res_o = SMIN[W-1:0];
            sat_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mulh_bank.sv
module mulh_bank
   import mulh_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int W     = 8
) (
   input  logic [VEC_W-1:0]   a_vec,
   input  logic [VEC_W-1:0]   b_vec,
   input  logic [W-1:0]       scalar,
   input  logic               scalar_sel,
   input  mh_op_e             op,
   input  logic               uns,
   output logic [VEC_W-1:0]   res_vec,
   output logic [VEC_W/8-1:0] sat_byte
);
   localparam int NL  = VEC_W / W;
   localparam int BPL = W / 8;

   generate
      if ((W % 8) != 0 || (VEC_W % W) != 0) begin : g_bad_geom
         $error("mulh_bank: lane width must be a byte multiple dividing the vector");
      end
   endgenerate

   for (genvar g = 0; g < NL; g++) begin : g_lane
      logic [W-1:0] b_lane;
      logic         lane_sat;

      assign b_lane = scalar_sel ? scalar : b_vec[g*W +: W];

      mulh_core #(.W(W)) u_core (
         .a_i   (a_vec[g*W +: W]),
         .b_i   (b_lane),
         .op_i  (op),
         .uns_i (uns),
         .res_o (res_vec[g*W +: W]),
         .sat_o (lane_sat)
      );

      // the lowest byte of a lane carries its saturation, the other bytes carry zero
      assign sat_byte[g*BPL] = lane_sat;
      if (BPL > 1) begin : g_pad
         assign sat_byte[g*BPL+1 +: BPL-1] = '0;
      end
   end

endmodule

// File: rtl/mulh_merge.sv
module mulh_merge #(
   parameter int VEC_W = 128
) (
   input  logic [VEC_W-1:0]   new_vec,
   input  logic [VEC_W-1:0]   old_vec,
   input  logic [VEC_W/8-1:0] en,
   output logic [VEC_W-1:0]   out_vec
);
   localparam int NB = VEC_W / 8;

   for (genvar j = 0; j < NB; j++) begin : g_byte
      assign out_vec[j*8 +: 8] = en[j] ? new_vec[j*8 +: 8] : old_vec[j*8 +: 8];
   end

endmodule

// File: rtl/mulh_lane_unit.sv
module mulh_lane_unit
   import mulh_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int SC_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [1:0]         op_sel,
   input  logic               op_unsigned,
   input  logic [1:0]         elem_size,
   input  logic               scalar_sel,
   input  logic [VEC_W-1:0]   vec_a,
   input  logic [VEC_W-1:0]   vec_b,
   input  logic [SC_W-1:0]    scalar_b,
   input  logic [VEC_W-1:0]   dest_old,
   input  logic [VEC_W/8-1:0] byte_en,
   input  logic               sat_clr,
   output logic [VEC_W-1:0]   dest_new,
   output logic               out_valid,
   output logic               sat_flag
);
   localparam int NB    = VEC_W / 8;
   localparam int MAX_W = lane_width(N_SIZES - 1);

   generate
      if (SC_W != MAX_W) begin : g_bad_scalar
         $error("mulh_lane_unit: scalar width must equal the widest lane");
      end
      if ((VEC_W % MAX_W) != 0) begin : g_bad_vec
         $error("mulh_lane_unit: vector width must be a multiple of the widest lane");
      end
   endgenerate

   mh_op_e           op;
   logic [VEC_W-1:0] bank_res [N_SIZES];
   logic [NB-1:0]    bank_sat [N_SIZES];
   logic [1:0]       sel_idx;
   logic [VEC_W-1:0] merged;
   logic             sat_any;

   assign op = mh_op_e'(op_sel);

   for (genvar k = 0; k < N_SIZES; k++) begin : g_bank
      localparam int LW = lane_width(k);
      mulh_bank #(.VEC_W(VEC_W), .W(LW)) u_bank (
         .a_vec      (vec_a),
         .b_vec      (vec_b),
         .scalar     (scalar_b[LW-1:0]),
         .scalar_sel (scalar_sel),
         .op         (op),
         .uns        (op_unsigned),
         .res_vec    (bank_res[k]),
         .sat_byte   (bank_sat[k])
      );
   end

   // codes 2 and 3 both pick the widest lanes
   assign sel_idx = elem_size[1] ? 2'd2 : {1'b0, elem_size[0]};
   assign sat_any = |(bank_sat[sel_idx] & byte_en);

   mulh_merge #(.VEC_W(VEC_W)) u_merge (
      .new_vec (bank_res[sel_idx]),
      .old_vec (dest_old),
      .en      (byte_en),
      .out_vec (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dest_new  <= '0;
         out_valid <= 1'b0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) dest_new <= merged;
         sat_flag <= (sat_flag & ~sat_clr) | (in_valid & sat_any);
      end
   end

   p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(dest_new)));
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clr) |=> sat_flag);
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr && !in_valid) |=> !sat_flag);
   p_nomask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && byte_en == '0) |=> (dest_new == $past(dest_old)));
   p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_flag && !in_valid) |=> !sat_flag);

endmodule

// File: tb/mulh_lane_unit_bench.sv
module mulh_lane_unit_bench;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [1:0]   op_sel;
   logic         op_unsigned;
   logic [1:0]   elem_size;
   logic         scalar_sel;
   logic [127:0] vec_a, vec_b, dest_old;
   logic [31:0]  scalar_b;
   logic [15:0]  byte_en;
   logic         sat_clr;
   logic [127:0] dest_new;
   logic         out_valid, sat_flag;

   int           total = 0;
   int           bad = 0;
   bit           done = 0;
   logic         exp_flag = 1'b0;
   logic [127:0] exp_dest;

   always #5 clk = ~clk;

   mulh_lane_unit u_mulh_lane_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .op_unsigned(op_unsigned), .elem_size(elem_size), .scalar_sel(scalar_sel),
      .vec_a(vec_a), .vec_b(vec_b), .scalar_b(scalar_b), .dest_old(dest_old),
      .byte_en(byte_en), .sat_clr(sat_clr), .dest_new(dest_new),
      .out_valid(out_valid), .sat_flag(sat_flag)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic longint sx(input logic [31:0] v, input int w);
      longint m = (longint'(1) << w) - 1;
      longint r = longint'(v) & m;
      if (v[w-1]) r = r - (longint'(1) << w);
      return r;
   endfunction

   function automatic logic [31:0] lane_ref(input logic [31:0] a, input logic [31:0] b,
                                             input int w, input int op, input bit uns,
                                             output bit sat);
      longint m = (longint'(1) << w) - 1;
      longint p, q, mx, mn;
      longint unsigned pu;
      sat = 0;
      if (op < 2 && uns) begin
         pu = (longint'(a) & m) * (longint'(b) & m);
         if (op == 1) pu = pu + (longint'(1) << (w - 1));
         return 32'(pu >> w);
      end
      p = sx(a, w) * sx(b, w);
      if (op < 2) begin
         if (op == 1) p = p + (longint'(1) << (w - 1));
         q = p >>> w;
         return 32'(q & m);
      end
      if (op == 3) p = p + (longint'(1) << (w - 2));
      q  = p >>> (w - 1);
      mx = (longint'(1) << (w - 1)) - 1;
      mn = -mx - 1;
      if (q > mx) begin sat = 1; q = mx; end
      else if (q < mn) begin sat = 1; q = mn; end
      return 32'(q & m);
   endfunction

   // one strobe, then check the registered outputs one cycle later
   task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [31:0] sc,
                         input bit ssel, input logic [127:0] old, input logic [15:0] en,
                         input logic [1:0] op, input bit uns, input logic [1:0] sz,
                         input bit clr, input string tag);
      int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      logic [127:0] full = '0;
      bit any = 0;
      for (int e = 0; e < 128 / w; e++) begin
         bit s;
         logic [31:0] al = 32'(a >> (e * w)) & m;
         logic [31:0] bl = ssel ? (sc & m) : (32'(b >> (e * w)) & m);
         logic [31:0] r  = lane_ref(al, bl, w, int'(op), uns, s);
         full = full | (128'(r) << (e * w));
         if (s && en[e * w / 8]) any = 1;
      end
      for (int j = 0; j < 16; j++)
         exp_dest[j*8 +: 8] = en[j] ? full[j*8 +: 8] : old[j*8 +: 8];
      @(negedge clk);
      vec_a = a; vec_b = b; scalar_b = sc; scalar_sel = ssel; dest_old = old;
      byte_en = en; op_sel = op; op_unsigned = uns; elem_size = sz;
      sat_clr = clr; in_valid = 1'b1;
      exp_flag = (exp_flag & ~clr) | any;
      @(negedge clk);
      in_valid = 1'b0; sat_clr = 1'b0;
      chk(dest_new == exp_dest, tag, dest_new, exp_dest);
      chk(out_valid == 1'b1, "R10 out_valid", 128'(out_valid), 128'd1);
      chk(sat_flag == exp_flag, "R8/R9 flag", 128'(sat_flag), 128'(exp_flag));
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] hold;
      void'($urandom(32'd7331));
      rst_n = 1'b0; in_valid = 0; op_sel = 0; op_unsigned = 0; elem_size = 0;
      scalar_sel = 0; vec_a = '0; vec_b = '0; scalar_b = '0; dest_old = '0;
      byte_en = '0; sat_clr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(dest_new == '0, "R10 reset dest", dest_new, '0);
      chk(out_valid == 1'b0, "R10 reset valid", 128'(out_valid), 128'd0);
      chk(sat_flag == 1'b0, "R10 reset flag", 128'(sat_flag), 128'd0);

      // R1 signed 8-bit: -128 * -128 >> 8 = 0x40
      run_op({16{8'h80}}, {16{8'h80}}, 0, 0, '0, 16'hFFFF, 2'd0, 0, 2'd0, 0, "R1 signed8");
      chk(dest_new == {16{8'h40}}, "R1 value", dest_new, {16{8'h40}});
      // R10 hold after the strobe
      hold = dest_new;
      @(negedge clk);
      chk(out_valid == 1'b0 && dest_new == hold, "R10 hold", dest_new, hold);
      // R1 unsigned 16-bit: 0xFFFF * 0xFFFF >> 16 = 0xFFFE
      run_op({8{16'hFFFF}}, {8{16'hFFFF}}, 0, 0, '0, 16'hFFFF, 2'd0, 1, 2'd1, 0, "R1 unsigned16");
      chk(dest_new == {8{16'hFFFE}}, "R1 value16", dest_new, {8{16'hFFFE}});
      // R2 rounding 32-bit
      run_op(rnd128(), rnd128(), 0, 0, rnd128(), 16'hFFFF, 2'd1, 0, 2'd2, 0, "R2 round32s");
      run_op(rnd128(), rnd128(), 0, 0, rnd128(), 16'h0F0F, 2'd1, 1, 2'd0, 0, "R2 round8u");
      // R3 saturation of -1 * -1 in 16-bit lanes
      run_op({8{16'h8000}}, {8{16'h8000}}, 0, 0, '0, 16'hFFFF, 2'd2, 0, 2'd1, 0, "R3 sat16");
      chk(dest_new == {8{16'h7FFF}}, "R3 clamp", dest_new, {8{16'h7FFF}});
      // R3 unsigned select has no effect
      run_op({8{16'h8000}}, {8{16'h8000}}, 0, 0, '0, 16'hFFFF, 2'd2, 1, 2'd1, 0, "R3 uns ignored");
      chk(dest_new == {8{16'h7FFF}}, "R3 uns clamp", dest_new, {8{16'h7FFF}});
      // R9 clear alone
      @(negedge clk); sat_clr = 1'b1;
      @(negedge clk); sat_clr = 1'b0; exp_flag = 0;
      chk(sat_flag == 1'b0, "R9 clear", 128'(sat_flag), 128'd0);
      // R8 saturating lane 0 with its low byte disabled: no flag, R7 byte 1 written
      run_op({{7{16'h0100}}, 16'h8000}, {{7{16'h0100}}, 16'h8000}, 0, 0, {16{8'hA5}},
             16'hFFFE, 2'd3, 0, 2'd1, 0, "R8/R7 masked lane");
      chk(sat_flag == 1'b0, "R8 inactive lane", 128'(sat_flag), 128'd0);
      chk(dest_new[7:0] == 8'hA5 && dest_new[15:8] == 8'h7F, "R7 merge bytes",
          128'(dest_new[15:0]), 128'h7FA5);
      // R4 rounding saturating 8-bit
      run_op(rnd128(), rnd128(), 0, 0, rnd128(), 16'hFFFF, 2'd3, 1, 2'd0, 0, "R4 qrd8");
      // R6 scalar mode
      run_op(rnd128(), rnd128(), 32'hABCD_0003, 1, rnd128(), 16'hFFFF, 2'd0, 0, 2'd1, 0, "R6 scalar16");
      run_op(rnd128(), rnd128(), 32'h8000_0000, 1, rnd128(), 16'hFFFF, 2'd2, 0, 2'd2, 0, "R6 scalar32");
      // R5 code 3 behaves as 32-bit lanes
      run_op(rnd128(), rnd128(), 0, 0, rnd128(), 16'hFFFF, 2'd1, 0, 2'd3, 0, "R5 size3");
      // R9 clear and saturation in the same cycle: set wins
      run_op({4{32'h8000_0000}}, {4{32'h8000_0000}}, 0, 0, '0, 16'h0001, 2'd2, 0, 2'd2, 1, "R9 clr+set");
      chk(sat_flag == 1'b1, "R9 set wins", 128'(sat_flag), 128'd1);
      // R7 all bytes disabled
      run_op(rnd128(), rnd128(), 0, 0, {8{16'h1234}}, 16'h0000, 2'd0, 0, 2'd0, 0, "R7 none enabled");

      for (int i = 0; i < 300; i++) begin
         logic [127:0] ra = rnd128();
         logic [127:0] rb = rnd128();
         if ($urandom_range(0, 3) == 0) begin
            ra = ra | {16{8'h80}} & {16{8'hFF}};
            rb = ra;
         end
         run_op(ra, rb, $urandom(), bit'($urandom_range(0, 1)), rnd128(), 16'($urandom()),
                2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                ($urandom_range(0, 7) == 0), "R1-4/R5 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule